// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error-Tagged FIFO

This block receives asynchronous serial words from a single line. It runs from the system clock. A programmable divisor produces a tick sixteen times per bit. The receiver confirms a start bit at mid-bit and samples each data bit at the centre of its period. Words of eight bits without parity, eight bits with even or odd parity, or nine bits are accepted, followed by one or two stop bits. Each finished word goes into a four-entry receive queue. Its framing-error and parity-error flags are stored with it and leave the queue with it.

The host reads the head of the queue on `popData`, `popFramErr` and `popParErr`, and removes it by pulsing `popReq`. A one-cycle `irqPulse` is raised either on every stored word or only once the queue holds at least three words. In nine-bit mode with address detection on, any word whose ninth bit is set always interrupts. A held-low line (break) yields a single all-zero word that carries a framing error. The receiver then waits for the line to return high before it will accept a new start. For self-test, a loopback select takes the local transmitter's line in place of the external pin.

Top module: `serial_rx`

## Requirements
- R1: One bit lasts 16*(baudDiv+1) clock cycles; frames sent at that rate are received correctly for baudDiv values 0, 1 and 3.
- R2: fmtSel selects the format: 00 = 8 data bits, no parity; 01 = 8 bits + even parity; 10 = 8 bits + odd parity; 11 = 9 data bits, no parity. Data is sent LSB first. An 8-bit word appears on popData[7:0] with popData[8]=0.
- R3: popParErr of a word is 1 when its parity bit disagrees with the even/odd mode. It is 0 in formats 00 and 11.
- R4: popFramErr of a word is 1 when a stop sample is low. With twoStop=1, a low second stop bit alone sets it.
- R5: Words leave the queue in arrival order, each with its own flags. dataAvail is 1 while the queue holds a word. popReq removes the head word.
- R6: rxIdle is 0 from start-bit detection until the last stop bit is sampled, and 1 otherwise.
- R7: A line held low for more than 13 bit times stores exactly one word: data 0 with popFramErr=1, and rxIdle returns to 1 while the line is still low. No further word is stored until the line goes high. A normal frame sent after that is received.
- R8: A word that completes while the four-entry queue is full is dropped, and the sticky overrun output goes to 1 until reset.
- R9: With irqDeep=0, irqPulse fires once for each stored word. With irqDeep=1, it fires only when a store leaves three or more words in the queue.
- R10: With addrDetEn=1 and fmtSel=11, a stored word whose bit 8 is 1 fires irqPulse whatever irqDeep is.
- R11: With loopEn=1, txLine feeds the receiver and rxPin is ignored. With loopEn=0, rxPin feeds it.
- R12: After reset the queue is empty, dataAvail=0, rxIdle=1, overrun=0, irqPulse=0, and the head flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxPin | input | 1 | External serial input |
| txLine | input | 1 | Local transmitter line, used in loopback |
| loopEn | input | 1 | 1 selects txLine as the receive source |
| fmtSel | input | 2 | Data/parity format select |
| twoStop | input | 1 | 0 = one stop bit, 1 = two |
| addrDetEn | input | 1 | Address detection in nine-bit mode |
| irqDeep | input | 1 | 0 = interrupt per word, 1 = at three or more words |
| baudDiv | input | 16 | Bit-rate divisor |
| popReq | input | 1 | Removes the head word |
| popData | output | 9 | Head word data |
| popFramErr | output | 1 | Head word framing error |
| popParErr | output | 1 | Head word parity error |
| dataAvail | output | 1 | Queue not empty |
| fifoCount | output | 3 | Words held |
| overrun | output | 1 | Sticky: a word was dropped |
| rxIdle | output | 1 | Receiver idle |
| irqPulse | output | 1 | One-cycle interrupt request |

## Verification
The bench keeps the default parameters: 16x oversampling, a four-entry queue and a threshold of three. With four entries, overrun follows after only five frames. With a threshold of three, the deep-interrupt rule changes its decision within one short burst. The divisor is a port and not a parameter, so the bench changes it at run time to 0, 1 and 3. This covers the fastest rate and two slower ones without rebuilding the design. Because the oversample rate is sixteen, a break test of fourteen bit times stays under a few thousand cycles.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_WAITHI
  } rxState_t;

  typedef struct packed {
    logic clear;
    logic shiftBit;
    logic capPar;
    logic capStop;
    logic push;
  } rxStrobe_t;

  typedef struct packed {
    logic [8:0] data;
    logic       frameErr;
    logic       parErr;
  } rxWord_t;

  localparam logic [1:0] FMT_8N = 2'b00;
  localparam logic [1:0] FMT_8E = 2'b01;
  localparam logic [1:0] FMT_8O = 2'b10;
  localparam logic [1:0] FMT_9N = 2'b11;
endpackage

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int OS_RATE = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic [1:0]       fmtSel,
  input  logic             twoStop,
  input  logic             lineSync,
  output rxStrobe_t        strb,
  output logic             rxIdle
);
  localparam int OS_W = $clog2(OS_RATE);
  localparam logic [OS_W-1:0] MID  = OS_W'(OS_RATE / 2 - 1);
  localparam logic [OS_W-1:0] LAST = OS_W'(OS_RATE - 1);

  logic [DIV_W-1:0] divCnt;
  logic             tick;
  rxState_t         st, stNext;
  logic [OS_W-1:0]  osCnt, osNext;
  logic [3:0]       bitCnt, bitNext;
  logic             stopCnt, stopNext;
  logic [3:0]       lastBit;
  logic             hasPar;

  assign tick    = (divCnt == baudDiv);
  assign lastBit = (fmtSel == FMT_9N) ? 4'd8 : 4'd7;
  assign hasPar  = (fmtSel == FMT_8E) || (fmtSel == FMT_8O);
  assign rxIdle  = (st == ST_IDLE) || (st == ST_WAITHI);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (tick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    stNext   = st;
    osNext   = osCnt;
    bitNext  = bitCnt;
    stopNext = stopCnt;
    strb     = '0;
    case (st)
      ST_IDLE: if (tick && !lineSync) begin
        stNext = ST_START;
        osNext = '0;
      end
      ST_START: if (tick) begin
        if (osCnt == MID) begin
          osNext = '0;
          if (!lineSync) begin
            stNext     = ST_DATA;
            strb.clear = 1'b1;
            bitNext    = '0;
          end else begin
            stNext = ST_IDLE;
          end
        end else osNext = osCnt + 1'b1;
      end
      ST_DATA: if (tick) begin
        if (osCnt == LAST) begin
          strb.shiftBit = 1'b1;
          osNext        = '0;
          bitNext       = bitCnt + 1'b1;
          if (bitCnt == lastBit) begin
            stNext   = hasPar ? ST_PAR : ST_STOP;
            stopNext = 1'b0;
          end
        end else osNext = osCnt + 1'b1;
      end
      ST_PAR: if (tick) begin
        if (osCnt == LAST) begin
          strb.capPar = 1'b1;
          osNext      = '0;
          stNext      = ST_STOP;
          stopNext    = 1'b0;
        end else osNext = osCnt + 1'b1;
      end
      ST_STOP: if (tick) begin
        if (osCnt == LAST) begin
          strb.capStop = 1'b1;
          osNext       = '0;
          if (stopCnt == twoStop) begin
            strb.push = 1'b1;
            stNext    = ST_WAITHI;
          end else stopNext = 1'b1;
        end else osNext = osCnt + 1'b1;
      end
      ST_WAITHI: if (lineSync) stNext = ST_IDLE;
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      osCnt   <= '0;
      bitCnt  <= '0;
      stopCnt <= 1'b0;
    end else begin
      st      <= stNext;
      osCnt   <= osNext;
      bitCnt  <= bitNext;
      stopCnt <= stopNext;
    end
  end
endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import serial_rx_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int DEEP_LEVEL = 3,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxPin,
  input  logic             txLine,
  input  logic             loopEn,
  input  logic [1:0]       fmtSel,
  input  logic             addrDetEn,
  input  logic             irqDeep,
  input  rxStrobe_t        strb,
  input  logic             popReq,
  output logic             lineSync,
  output logic [8:0]       popData,
  output logic             popFramErr,
  output logic             popParErr,
  output logic             dataAvail,
  output logic [CNT_W-1:0] fifoCount,
  output logic             overrun,
  output logic             irqPulse
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [1:0]       syncQ;
  logic [8:0]       shiftReg;
  logic             parBit, ferrAcc;
  rxWord_t          mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] newCount;
  logic             full, doPush, doPop, addrHit;
  rxWord_t          newWord;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // receive source mux ahead of the synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else syncQ <= {syncQ[0], loopEn ? txLine : rxPin};
  end
  assign lineSync = syncQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      ferrAcc  <= 1'b0;
    end else begin
      if (strb.clear) begin
        shiftReg <= '0;
        parBit   <= 1'b0;
        ferrAcc  <= 1'b0;
      end
      if (strb.shiftBit) shiftReg <= {lineSync, shiftReg[8:1]};
      if (strb.capPar)   parBit   <= lineSync;
      if (strb.capStop)  ferrAcc  <= ferrAcc | !lineSync;
    end
  end

  always_comb begin
    newWord.data     = (fmtSel == FMT_9N) ? shiftReg : {1'b0, shiftReg[8:1]};
    newWord.frameErr = ferrAcc | !lineSync;
    case (fmtSel)
      FMT_8E:  newWord.parErr = ^newWord.data[7:0] ^ parBit;
      FMT_8O:  newWord.parErr = ~(^newWord.data[7:0] ^ parBit);
      default: newWord.parErr = 1'b0;
    endcase
  end

  assign doPop    = popReq && (fifoCount != '0);
  assign full     = (fifoCount == CNT_W'(DEPTH)) && !doPop;
  assign doPush   = strb.push && !full;
  assign addrHit  = addrDetEn && (fmtSel == FMT_9N) && newWord.data[8];
  assign newCount = fifoCount + CNT_W'(doPush) - CNT_W'(doPop);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
      overrun   <= 1'b0;
      irqPulse  <= 1'b0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= newWord;
        wrPtr      <= bump(wrPtr);
      end
      if (doPop) rdPtr <= bump(rdPtr);
      fifoCount <= newCount;
      if (strb.push && full) overrun <= 1'b1;
      irqPulse <= doPush && (addrHit || !irqDeep || (newCount >= CNT_W'(DEEP_LEVEL)));
    end
  end

  assign popData    = mem[rdPtr].data;
  assign popFramErr = mem[rdPtr].frameErr;
  assign popParErr  = mem[rdPtr].parErr;
  assign dataAvail  = (fifoCount != '0);
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int OS_RATE    = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int DEEP_LEVEL = 3
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            rxPin,
  input  logic                            txLine,
  input  logic                            loopEn,
  input  logic [1:0]                      fmtSel,
  input  logic                            twoStop,
  input  logic                            addrDetEn,
  input  logic                            irqDeep,
  input  logic [DIV_W-1:0]                baudDiv,
  input  logic                            popReq,
  output logic [8:0]                      popData,
  output logic                            popFramErr,
  output logic                            popParErr,
  output logic                            dataAvail,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] fifoCount,
  output logic                            overrun,
  output logic                            rxIdle,
  output logic                            irqPulse
);
  rxStrobe_t strb;
  logic      lineSync;

  rx_ctrl #(.DIV_W(DIV_W), .OS_RATE(OS_RATE)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudDiv(baudDiv), .fmtSel(fmtSel),
    .twoStop(twoStop), .lineSync(lineSync), .strb(strb), .rxIdle(rxIdle)
  );

  rx_datapath #(.DEPTH(FIFO_DEPTH), .DEEP_LEVEL(DEEP_LEVEL)) u_dp (
    .clk(clk), .rstN(rstN), .rxPin(rxPin), .txLine(txLine), .loopEn(loopEn),
    .fmtSel(fmtSel), .addrDetEn(addrDetEn), .irqDeep(irqDeep), .strb(strb),
    .popReq(popReq), .lineSync(lineSync), .popData(popData),
    .popFramErr(popFramErr), .popParErr(popParErr), .dataAvail(dataAvail),
    .fifoCount(fifoCount), .overrun(overrun), .irqPulse(irqPulse)
  );
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [$clog2(DEPTH+1)-1:0] fifoCount,
  input logic                       overrun,
  input logic                       irqPulse,
  input logic                       rxIdle,
  input logic                       dataAvail
);
  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= ($clog2(DEPTH+1))'(DEPTH)); // R8
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun); // R8
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R9
  AST_IRQ_HAS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> dataAvail); // R9
  AST_IDLE_AFTER_STORE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> rxIdle); // R6
endmodule

bind serial_rx serial_rx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .fifoCount(fifoCount), .overrun(overrun),
  .irqPulse(irqPulse), .rxIdle(rxIdle), .dataAvail(dataAvail)
);

// File: tb/serial_rx_bench.sv
module serial_rx_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxPin = 1'b1, txLine = 1'b1, loopEn = 1'b0;
  logic [1:0] fmtSel = 2'b00;
  logic       twoStop = 1'b0, addrDetEn = 1'b0, irqDeep = 1'b0;
  logic [15:0] baudDiv = 16'd1;
  logic       popReq = 1'b0;
  logic [8:0] popData;
  logic       popFramErr, popParErr, dataAvail, overrun, rxIdle, irqPulse;
  logic [2:0] fifoCount;

  int checks = 0, failures = 0, irqTotal = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) if (rstN && irqPulse) irqTotal++;

  serial_rx u_serial_rx (
    .clk(clk), .rstN(rstN), .rxPin(rxPin), .txLine(txLine), .loopEn(loopEn),
    .fmtSel(fmtSel), .twoStop(twoStop), .addrDetEn(addrDetEn), .irqDeep(irqDeep),
    .baudDiv(baudDiv), .popReq(popReq), .popData(popData), .popFramErr(popFramErr),
    .popParErr(popParErr), .dataAvail(dataAvail), .fifoCount(fifoCount),
    .overrun(overrun), .rxIdle(rxIdle), .irqPulse(irqPulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; rxPin = 1'b1; txLine = 1'b1; loopEn = 1'b0; fmtSel = 2'b00;
    twoStop = 1'b0; addrDetEn = 1'b0; irqDeep = 1'b0; baudDiv = 16'd1; popReq = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  function automatic int bitClk();
    return 16 * (int'(baudDiv) + 1);
  endfunction

  // builds start, data LSB first, optional parity, stops; drives one line
  task automatic sendFrame(input logic [8:0] d, input bit flipPar, input bit badStop,
                           input bit useTx, input bit probeIdle);
    logic [15:0] b = '1;
    int n = 0, nb;
    b[n] = 1'b0; n++;
    nb = (fmtSel == 2'b11) ? 9 : 8;
    for (int i = 0; i < nb; i++) begin b[n] = d[i]; n++; end
    if (fmtSel == 2'b01 || fmtSel == 2'b10) begin
      b[n] = (^d[7:0]) ^ (fmtSel == 2'b10) ^ flipPar; n++;
    end
    b[n] = 1'b1; n++;
    if (twoStop) begin b[n] = 1'b1; n++; end
    if (badStop) b[n-1] = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (useTx) txLine = b[i]; else rxPin = b[i];
      repeat (bitClk() / 2) @(negedge clk);
      if (probeIdle && i == 3) chk("R6 idle low mid-frame", rxIdle, 1'b0);
      repeat (bitClk() - bitClk() / 2) @(negedge clk);
    end
    if (useTx) txLine = 1'b1; else rxPin = 1'b1;
    repeat (bitClk()) @(negedge clk);
  endtask

  task automatic popOne(input string tag, input logic [8:0] d, input bit fe, input bit pe);
    chk({tag, " avail"}, dataAvail, 1'b1);
    chk({tag, " data"}, popData, d);
    chk({tag, " framErr"}, popFramErr, fe);
    chk({tag, " parErr"}, popParErr, pe);
    popReq = 1'b1; @(negedge clk); popReq = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    doReset();
    chk("R12 count", fifoCount, 0);
    chk("R12 avail", dataAvail, 0);
    chk("R12 idle", rxIdle, 1);
    chk("R12 overrun", overrun, 0);
    chk("R12 irq", irqPulse, 0);
    chk("R12 flags", {popFramErr, popParErr}, 0);
  endtask

  task automatic t_rates();
    doReset();
    sendFrame(9'h0A5, 0, 0, 0, 1);
    chk("R6 idle after frame", rxIdle, 1);
    popOne("R1 R2 div1", 9'h0A5, 0, 0);
    chk("R5 empty after pop", dataAvail, 0);
    baudDiv = 16'd0;
    sendFrame(9'h03C, 0, 0, 0, 0);
    popOne("R1 div0", 9'h03C, 0, 0);
    baudDiv = 16'd3;
    sendFrame(9'h0C3, 0, 0, 0, 0);
    popOne("R1 div3", 9'h0C3, 0, 0);
  endtask

  task automatic t_parity();
    doReset();
    fmtSel = 2'b01;
    sendFrame(9'h05A, 0, 0, 0, 0);
    sendFrame(9'h05B, 1, 0, 0, 0);
    fmtSel = 2'b10;
    sendFrame(9'h007, 0, 0, 0, 0);
    sendFrame(9'h0F0, 1, 0, 0, 0);
    chk("R5 count four", fifoCount, 4);
    popOne("R3 even ok", 9'h05A, 0, 0);
    popOne("R3 even bad", 9'h05B, 0, 1);
    popOne("R3 odd ok", 9'h007, 0, 0);
    popOne("R3 odd bad", 9'h0F0, 0, 1);
  endtask

  task automatic t_nine();
    doReset();
    fmtSel = 2'b11;
    sendFrame(9'h1C3, 0, 0, 0, 0);
    popOne("R2 nine bit", 9'h1C3, 0, 0);
  endtask

  task automatic t_frame();
    doReset();
    sendFrame(9'h066, 0, 1, 0, 0);
    twoStop = 1'b1;
    sendFrame(9'h099, 0, 0, 0, 0);
    sendFrame(9'h081, 0, 1, 0, 0);
    popOne("R4 one stop low", 9'h066, 1, 0);
    popOne("R4 two stops ok", 9'h099, 0, 0);
    popOne("R4 second stop low", 9'h081, 1, 0);
  endtask

  task automatic t_break();
    doReset();
    rxPin = 1'b0;
    repeat (14 * bitClk()) @(negedge clk);
    chk("R7 one word", fifoCount, 1);
    chk("R7 idle while low", rxIdle, 1);
    repeat (6 * bitClk()) @(negedge clk);
    chk("R7 no rearm while low", fifoCount, 1);
    rxPin = 1'b1;
    repeat (2 * bitClk()) @(negedge clk);
    sendFrame(9'h03C, 0, 0, 0, 0);
    popOne("R7 break word", 9'h000, 1, 0);
    popOne("R7 frame after break", 9'h03C, 0, 0);
  endtask

  task automatic t_overrun();
    doReset();
    for (int i = 0; i < 4; i++) sendFrame(9'(8'h11 + i), 0, 0, 0, 0);
    chk("R8 no overrun yet", overrun, 0);
    sendFrame(9'h015, 0, 0, 0, 0);
    chk("R8 overrun", overrun, 1);
    chk("R8 count", fifoCount, 4);
    for (int i = 0; i < 4; i++) popOne("R8 kept", 9'(8'h11 + i), 0, 0);
    chk("R8 sticky", overrun, 1);
  endtask

  task automatic t_irq();
    int base;
    doReset();
    base = irqTotal;
    sendFrame(9'h041, 0, 0, 0, 0);
    chk("R9 per word", irqTotal - base, 1);
    doReset();
    irqDeep = 1'b1;
    base = irqTotal;
    sendFrame(9'h042, 0, 0, 0, 0);
    sendFrame(9'h043, 0, 0, 0, 0);
    chk("R9 deep below level", irqTotal - base, 0);
    sendFrame(9'h044, 0, 0, 0, 0);
    chk("R9 deep at level", irqTotal - base, 1);
  endtask

  task automatic t_addr();
    int base;
    doReset();
    irqDeep = 1'b1; fmtSel = 2'b11; addrDetEn = 1'b1;
    base = irqTotal;
    sendFrame(9'h055, 0, 0, 0, 0);
    chk("R10 data word silent", irqTotal - base, 0);
    sendFrame(9'h1AA, 0, 0, 0, 0);
    chk("R10 address word irq", irqTotal - base, 1);
  endtask

  task automatic t_loop();
    doReset();
    loopEn = 1'b1;
    sendFrame(9'h0E7, 0, 0, 1, 0);
    chk("R11 loop count", fifoCount, 1);
    sendFrame(9'h000, 0, 0, 0, 0);
    chk("R11 pin ignored", fifoCount, 1);
    popOne("R11 loop word", 9'h0E7, 0, 0);
    loopEn = 1'b0;
    sendFrame(9'h018, 0, 0, 1, 0);
    chk("R11 tx ignored normal", fifoCount, 0);
  endtask

  initial begin
    t_reset();
    t_rates();
    t_parity();
    t_nine();
    t_frame();
    t_break();
    t_overrun();
    t_irq();
    t_addr();
    t_loop();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule